// File: doc/BRIEF.md
# Two-Level Page Table Translator

This block turns an 18-bit virtual word address into a 19-bit physical address using 1K-word pages. The virtual page number is address bits 17:10 and the offset within the page is bits 9:0. Executive references to the lower half of the page space pass through untranslated. The upper half of the executive space has its own page table. User space uses two tables, one for the lower half and one for the upper half. Each table is located by a descriptor-base register. That register also carries a length limit for the table.

Translations are kept in two caches of page entries, one for user pages and one for executive upper-half pages. On a miss the block reads one 36-bit table word through a request/acknowledge memory port. Each table word packs the entries of two adjacent pages. The block stores the half that belongs to the requested page and completes the translation from it. A translation ends with either a physical address or a fault. On a fault the block records the cause in a sticky fault-status register and writes a fault-address word. The descriptor registers, the status register and the cache clear are driven through plain write ports.

Top module: `pager_xlat`

## Requirements
- R1: An executive reference (user flag low) to a page whose bit 7 is clear returns the virtual address unchanged as the physical address. No memory read is made, and the result pulse comes one cycle after the cycle in which the request is accepted.
- R2: When bit 2 (value 4) of the fault-status register is clear, every executive reference passes through unchanged, including pages with bit 7 set.
- R3: Base select 0 is used for user pages with bit 7 clear, and the relative page is the page itself. Select 1 is used for user pages with bit 7 set, and select 2 for executive pages with bit 7 set. For both of those the relative page is the page minus 0200 octal. A base write value holds the table origin in bits 17:0 and the table length in bits 24:18.
- R4: The table word address is the origin plus the relative page shifted right by one. An even page takes word bits 35:18 as its entry, and an odd page takes word bits 17:0.
- R5: On a miss where the relative page shifted right by one is greater than the table length, the result is a fault. Fault-status bit 7 (value 0200) is set and no memory read is made.
- R6: A translated physical address is entry bits 8:0 placed above the 10-bit offset.
- R7: A loaded nonzero entry is reused without a memory read. A zero entry counts as not loaded and is read again on every reference. A cache clear forces a fresh read.
- R8: An instruction fetch made while pure mode is on faults when entry bits 17:16 are not binary 01. Fault-status bit 4 (value 020) is set in that case.
- R9: Every fault writes a fault-address word. Bits 7:0 hold the page, bit 8 is the user flag, and bits 17:9 hold entry bits 8:0. Those entry bits are zero for a length fault.
- R10: A request is accepted only while ready is high, and ready stays low until the result. The memory request is held with a stable address until it is acknowledged. The result valid lasts one cycle, and the fault flag is only raised together with it.
- R11: After reset, ready is high, no result or memory request is active, the fault-status register is zero and both caches are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 18 | Virtual address |
| req_user | input | 1 | Reference is to user space |
| req_fetch | input | 1 | Reference is an instruction fetch |
| pure_mode | input | 1 | Pure-page checking on fetch |
| req_ready | output | 1 | Block is idle and takes a request |
| base_we | input | 1 | Descriptor-base write strobe |
| base_sel | input | 2 | Descriptor-base select (0, 1, 2) |
| base_wdata | input | 25 | Length in bits 24:18, origin in bits 17:0 |
| status_we | input | 1 | Fault-status write strobe |
| status_wdata | input | 18 | Fault-status write value |
| cache_clr | input | 1 | Empties both entry caches |
| mem_req | output | 1 | Table word read request |
| mem_addr | output | 18 | Table word address |
| mem_ack | input | 1 | Read acknowledge, data valid in the same cycle |
| mem_rdata | input | 36 | Table word |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_paddr | output | 19 | Physical address |
| fault_status | output | 18 | Sticky fault-status register |
| fault_addr | output | 18 | Fault-address word |

## Verification
A direct mapping or a cache hit gives its result pulse exactly one cycle after the accepting edge. The bench counts falling edges from acceptance and requires that count to be one on those paths. A miss adds the memory wait plus one cycle, so for misses the bench waits for the pulse and counts memory reads to tell hits from refills. Inputs change on falling edges, and the result, status and fault address are all sampled at the falling edge where the pulse is high, after the register updates have settled.

// File: rtl/pt_pkg.sv
package pt_pkg;
    localparam int VA_W    = 18;
    localparam int OFF_W   = 10;
    localparam int PG_W    = VA_W - OFF_W;
    localparam int ENT_W   = 18;
    localparam int WORD_W  = 2 * ENT_W;
    localparam int FRAME_W = 9;
    localparam int PA_W    = FRAME_W + OFF_W;
    localparam int LEN_W   = PG_W - 1;
    localparam int BASE_W  = LEN_W + VA_W;
    localparam int STAT_W  = 18;
    localparam int NBASE   = 3;
    localparam int U_DEPTH = 1 << PG_W;
    localparam int E_DEPTH = 1 << (PG_W - 1);

    localparam int BIT_PAGING = 2;
    localparam int BIT_PURE   = 4;
    localparam int BIT_LEN    = 7;

    typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_MEM} pt_state_e;

    typedef struct packed {
        logic [VA_W-1:0] addr;
        logic            user;
        logic            fetch;
    } pt_req_t;

    function automatic logic [VA_W-1:0] tbl_word_addr(input logic [BASE_W-1:0] base,
                                                      input logic [PG_W-1:0] rel);
        return base[VA_W-1:0] + VA_W'(rel >> 1);
    endfunction

    function automatic logic len_over(input logic [BASE_W-1:0] base,
                                      input logic [PG_W-1:0] rel);
        return rel[PG_W-1:1] > base[BASE_W-1 -: LEN_W];
    endfunction

    function automatic logic [PA_W-1:0] phys(input logic [ENT_W-1:0] ent,
                                             input logic [OFF_W-1:0] off);
        return {ent[FRAME_W-1:0], off};
    endfunction

    function automatic logic pure_ok(input logic [ENT_W-1:0] ent);
        return ent[ENT_W-1 -: 2] == 2'b01;
    endfunction

    function automatic logic [STAT_W-1:0] fault_word(input logic [PG_W-1:0] page,
                                                     input logic user,
                                                     input logic [ENT_W-1:0] ent);
        return {ent[FRAME_W-1:0], user, page};
    endfunction
endpackage

// File: rtl/pt_cache.sv
module pt_cache
    import pt_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_data
);
    logic [ENT_W-1:0] slot [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || clr)
                slot[gi] <= '0;
            else if (wr_en && wr_idx == IDX_W'(gi))
                slot[gi] <= wr_data;
        end
    end

    assign rd_data = slot[rd_idx];
endmodule

// File: rtl/pt_route.sv
module pt_route
    import pt_pkg::*;
(
    input  pt_req_t           req,
    input  logic              paging_on,
    input  logic [BASE_W-1:0] base_ulo,
    input  logic [BASE_W-1:0] base_uhi,
    input  logic [BASE_W-1:0] base_ehi,
    output logic              direct,
    output logic [BASE_W-1:0] sel_base,
    output logic [PG_W-1:0]   rel_page
);
    logic [PG_W-1:0] page;
    logic            hi;

    always_comb begin
        page     = req.addr[VA_W-1 -: PG_W];
        hi       = page[PG_W-1];
        direct   = !req.user && (!hi || !paging_on);
        rel_page = hi ? {1'b0, page[PG_W-2:0]} : page;
        if (req.user)
            sel_base = hi ? base_uhi : base_ulo;
        else
            sel_base = base_ehi;
    end
endmodule

// File: rtl/pager_xlat.sv
module pager_xlat
    import pt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_addr,
    input  logic              req_user,
    input  logic              req_fetch,
    input  logic              pure_mode,
    output logic              req_ready,
    input  logic              base_we,
    input  logic [1:0]        base_sel,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic              status_we,
    input  logic [STAT_W-1:0] status_wdata,
    input  logic              cache_clr,
    output logic              mem_req,
    output logic [VA_W-1:0]   mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_paddr,
    output logic [STAT_W-1:0] fault_status,
    output logic [STAT_W-1:0] fault_addr
);
    pt_state_e         state;
    pt_req_t           req_q;
    logic [BASE_W-1:0] base_q [NBASE];
    logic [ENT_W-1:0]  fill_q;
    logic              fill_hit;

    logic [PG_W-1:0]   page;
    logic [OFF_W-1:0]  off;
    logic              direct;
    logic [BASE_W-1:0] sel_base;
    logic [PG_W-1:0]   rel_page;
    logic [ENT_W-1:0]  u_rd, e_rd, ent, half;
    logic              miss, lenf, puref, fill_we;
    logic [STAT_W-1:0] stat_set, stat_d;

    pt_route u_route (
        .req       (req_q),
        .paging_on (fault_status[BIT_PAGING]),
        .base_ulo  (base_q[0]),
        .base_uhi  (base_q[1]),
        .base_ehi  (base_q[2]),
        .direct    (direct),
        .sel_base  (sel_base),
        .rel_page  (rel_page)
    );

    pt_cache #(.DEPTH(U_DEPTH)) u_ucache (
        .clk     (clk),
        .rst     (rst),
        .clr     (cache_clr),
        .wr_en   (fill_we && req_q.user),
        .wr_idx  (page),
        .wr_data (half),
        .rd_idx  (page),
        .rd_data (u_rd)
    );

    pt_cache #(.DEPTH(E_DEPTH)) u_ecache (
        .clk     (clk),
        .rst     (rst),
        .clr     (cache_clr),
        .wr_en   (fill_we && !req_q.user),
        .wr_idx  (page[PG_W-2:0]),
        .wr_data (half),
        .rd_idx  (page[PG_W-2:0]),
        .rd_data (e_rd)
    );

    always_comb begin
        page     = req_q.addr[VA_W-1 -: PG_W];
        off      = req_q.addr[OFF_W-1:0];
        ent      = fill_hit ? fill_q : (req_q.user ? u_rd : e_rd);
        miss     = !fill_hit && (ent == '0);
        lenf     = len_over(sel_base, rel_page);
        puref    = req_q.fetch && pure_mode && !pure_ok(ent);
        half     = page[0] ? mem_rdata[ENT_W-1:0] : mem_rdata[WORD_W-1:ENT_W];
        fill_we  = (state == ST_MEM) && mem_ack;
        stat_set = '0;
        if (state == ST_LOOK && !direct) begin
            if (miss && lenf)
                stat_set[BIT_LEN] = 1'b1;
            else if (!miss && puref)
                stat_set[BIT_PURE] = 1'b1;
        end
        stat_d    = (status_we ? status_wdata : fault_status) | stat_set;
        req_ready = (state == ST_IDLE);
        mem_req   = (state == ST_MEM);
        mem_addr  = tbl_word_addr(sel_base, rel_page);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            req_q        <= '0;
            fill_q       <= '0;
            fill_hit     <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_paddr    <= '0;
            fault_status <= '0;
            fault_addr   <= '0;
            for (int i = 0; i < NBASE; i++)
                base_q[i] <= '0;
        end else begin
            rsp_valid    <= 1'b0;
            rsp_fault    <= 1'b0;
            fault_status <= stat_d;
            if (base_we && base_sel < 2'(NBASE))
                base_q[base_sel] <= base_wdata;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        req_q    <= '{addr: req_addr, user: req_user, fetch: req_fetch};
                        fill_hit <= 1'b0;
                        state    <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (direct) begin
                        rsp_valid <= 1'b1;
                        rsp_paddr <= PA_W'(req_q.addr);
                        state     <= ST_IDLE;
                    end else if (miss && lenf) begin
                        rsp_valid  <= 1'b1;
                        rsp_fault  <= 1'b1;
                        rsp_paddr  <= '0;
                        fault_addr <= fault_word(page, req_q.user, '0);
                        state      <= ST_IDLE;
                    end else if (miss) begin
                        state <= ST_MEM;
                    end else if (puref) begin
                        rsp_valid  <= 1'b1;
                        rsp_fault  <= 1'b1;
                        rsp_paddr  <= '0;
                        fault_addr <= fault_word(page, req_q.user, ent);
                        state      <= ST_IDLE;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_paddr <= phys(ent, off);
                        state     <= ST_IDLE;
                    end
                end
                ST_MEM: begin
                    if (mem_ack) begin
                        fill_q   <= half;
                        fill_hit <= 1'b1;
                        state    <= ST_LOOK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pager_xlat_sva.sv
module pager_xlat_sva
    import pt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              mem_req,
    input logic [VA_W-1:0]   mem_addr,
    input logic              mem_ack,
    input logic              rsp_valid,
    input logic              rsp_fault,
    input logic [STAT_W-1:0] fault_status
);
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R10
    AST_FAULT_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> rsp_valid); // R10
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10
    AST_BUSY_DURING_READ: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready); // R10
    AST_RSP_THEN_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready); // R10
    AST_FAULT_CAUSE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> ((fault_status & 18'o000220) != '0)); // R5
endmodule

bind pager_xlat pager_xlat_sva u_sva (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_ack      (mem_ack),
    .rsp_valid    (rsp_valid),
    .rsp_fault    (rsp_fault),
    .fault_status (fault_status)
);

// File: tb/sim_pager_xlat.sv
module sim_pager_xlat;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [17:0] req_addr = '0;
    logic        req_user = 1'b0;
    logic        req_fetch = 1'b0;
    logic        pure_mode = 1'b0;
    logic        req_ready;
    logic        base_we = 1'b0;
    logic [1:0]  base_sel = '0;
    logic [24:0] base_wdata = '0;
    logic        status_we = 1'b0;
    logic [17:0] status_wdata = '0;
    logic        cache_clr = 1'b0;
    logic        mem_req;
    logic [17:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [35:0] mem_rdata = '0;
    logic        rsp_valid, rsp_fault;
    logic [18:0] rsp_paddr;
    logic [17:0] fault_status, fault_addr;

    int checks = 0;
    int fails = 0;
    int reads = 0;
    int wait_cnt = 0;
    logic last_busy;
    logic done = 1'b0;

    pager_xlat u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [35:0] model_word(input logic [17:0] a);
        if (a == 18'o000777) return '0;
        return {2'b01, 7'd0, a[8:0], 2'b10, 7'd0, ~a[8:0]};
    endfunction

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            wait_cnt++;
            if (wait_cnt >= 2) begin
                mem_rdata = model_word(mem_addr);
                mem_ack = 1'b1;
                reads++;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%o expected=%o", tag, act, exp);
        end
    endtask

    task automatic set_base(input logic [1:0] s, input logic [24:0] v);
        @(negedge clk); base_sel = s; base_wdata = v; base_we = 1'b1;
        @(negedge clk); base_we = 1'b0;
    endtask

    task automatic set_status(input logic [17:0] v);
        @(negedge clk); status_wdata = v; status_we = 1'b1;
        @(negedge clk); status_we = 1'b0;
    endtask

    task automatic xlat(input logic [17:0] a, input logic u, input logic f,
                        output logic flt, output logic [18:0] pa, output int n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_user = u; req_fetch = f; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        last_busy = !req_ready;
        n = 0;
        while (!rsp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        flt = rsp_fault;
        pa = rsp_paddr;
    endtask

    task automatic t_reset;
        chk(req_ready == 1'b1, "R11 ready", 36'(req_ready), 36'd1);
        chk(rsp_valid == 1'b0 && mem_req == 1'b0, "R11 idle outputs", 36'({rsp_valid, mem_req}), 36'd0);
        chk(fault_status == '0, "R11 status", 36'(fault_status), 36'd0);
    endtask

    task automatic t_exec_low;
        logic f; logic [18:0] pa; int n; int r0;
        r0 = reads;
        xlat(18'o012345, 1'b0, 1'b0, f, pa, n);
        chk(!f && pa == 19'o012345, "R1 exec low direct", 36'(pa), 36'o012345);
        chk(n == 1 && reads == r0, "R1 latency and no read", 36'(n), 36'd1);
    endtask

    task automatic t_user_even;
        logic f; logic [18:0] pa; int n; int r0;
        r0 = reads;
        xlat({8'd4, 10'o123}, 1'b1, 1'b0, f, pa, n);
        chk(!f && pa == {9'o002, 10'o123}, "R4 R6 user even page", 36'(pa), 36'({9'o002, 10'o123}));
        chk(reads == r0 + 1, "R3 one table read", 36'(reads - r0), 36'd1);
        chk(last_busy, "R10 ready low while busy", 36'(last_busy), 36'd1);
    endtask

    task automatic t_user_hit;
        logic f; logic [18:0] pa; int n; int r0;
        r0 = reads;
        xlat({8'd4, 10'o777}, 1'b1, 1'b0, f, pa, n);
        chk(!f && pa == {9'o002, 10'o777}, "R7 hit address", 36'(pa), 36'({9'o002, 10'o777}));
        chk(reads == r0 && n == 1, "R7 hit no read", 36'(reads - r0), 36'd0);
    endtask

    task automatic t_user_odd;
        logic f; logic [18:0] pa; int n; int r0;
        r0 = reads;
        xlat({8'd5, 10'o077}, 1'b1, 1'b0, f, pa, n);
        chk(!f && pa == {9'o775, 10'o077}, "R4 odd page low half", 36'(pa), 36'({9'o775, 10'o077}));
        chk(reads == r0 + 1, "R4 odd page read", 36'(reads - r0), 36'd1);
    endtask

    task automatic t_pure;
        logic f; logic [18:0] pa; int n; int r0;
        r0 = reads;
        pure_mode = 1'b1;
        xlat({8'd5, 10'o001}, 1'b1, 1'b1, f, pa, n);
        chk(f == 1'b1, "R8 impure fetch faults", 36'(f), 36'd1);
        chk(fault_status == 18'o000024, "R8 status bit 4", 36'(fault_status), 36'o24);
        chk(fault_addr == {9'o775, 1'b1, 8'd5}, "R9 fault address", 36'(fault_addr), 36'({9'o775, 1'b1, 8'd5}));
        xlat({8'd4, 10'o001}, 1'b1, 1'b1, f, pa, n);
        chk(!f && pa == {9'o002, 10'o001}, "R8 pure entry fetch ok", 36'(pa), 36'({9'o002, 10'o001}));
        chk(reads == r0, "R8 served from cache", 36'(reads - r0), 36'd0);
        pure_mode = 1'b0;
    endtask

    task automatic t_user_high;
        logic f; logic [18:0] pa; int n;
        xlat({8'o203, 10'o005}, 1'b1, 1'b0, f, pa, n);
        chk(!f && pa == {9'o776, 10'o005}, "R3 user high base", 36'(pa), 36'({9'o776, 10'o005}));
    endtask

    task automatic t_length;
        logic f; logic [18:0] pa; int n; int r0;
        r0 = reads;
        xlat({8'o212, 10'o005}, 1'b1, 1'b0, f, pa, n);
        chk(f == 1'b1 && reads == r0, "R5 length fault no read", 36'(reads - r0), 36'd0);
        chk(fault_status == 18'o000224, "R5 status bit 7", 36'(fault_status), 36'o224);
        chk(fault_addr == {9'd0, 1'b1, 8'o212}, "R9 length fault address", 36'(fault_addr), 36'({9'd0, 1'b1, 8'o212}));
    endtask

    task automatic t_exec_high;
        logic f; logic [18:0] pa; int n;
        xlat({8'o300, 10'o017}, 1'b0, 1'b0, f, pa, n);
        chk(!f && pa == {9'o040, 10'o017}, "R3 exec high base", 36'(pa), 36'({9'o040, 10'o017}));
    endtask

    task automatic t_zero_entry;
        logic f; logic [18:0] pa; int n; int r0;
        set_base(2'd0, {7'd127, 18'o000700});
        r0 = reads;
        xlat({8'o176, 10'o031}, 1'b1, 1'b0, f, pa, n);
        chk(!f && pa == {9'd0, 10'o031}, "R6 zero entry frame", 36'(pa), 36'({9'd0, 10'o031}));
        xlat({8'o176, 10'o031}, 1'b1, 1'b0, f, pa, n);
        chk(reads == r0 + 2, "R7 zero entry reread", 36'(reads - r0), 36'd2);
    endtask

    task automatic t_clear;
        logic f; logic [18:0] pa; int n; int r0;
        @(negedge clk); cache_clr = 1'b1;
        @(negedge clk); cache_clr = 1'b0;
        r0 = reads;
        xlat({8'd4, 10'o123}, 1'b1, 1'b0, f, pa, n);
        chk(!f && pa == {9'o702, 10'o123}, "R7 clear forces refill", 36'(pa), 36'({9'o702, 10'o123}));
        chk(reads == r0 + 1, "R7 refill read", 36'(reads - r0), 36'd1);
    endtask

    task automatic t_paging_off;
        logic f; logic [18:0] pa; int n; int r0;
        set_status(18'o0);
        r0 = reads;
        xlat({8'o300, 10'o017}, 1'b0, 1'b0, f, pa, n);
        chk(!f && pa == {1'b0, 8'o300, 10'o017}, "R2 paging off direct", 36'(pa), 36'({8'o300, 10'o017}));
        chk(n == 1 && reads == r0, "R2 no read", 36'(reads - r0), 36'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        set_status(18'o000004);
        set_base(2'd0, {7'd10, 18'o001000});
        set_base(2'd1, {7'd3, 18'o002000});
        set_base(2'd2, {7'd63, 18'o003000});
        t_exec_low();
        t_user_even();
        t_user_hit();
        t_user_odd();
        t_pure();
        t_user_high();
        t_length();
        t_exec_high();
        t_zero_entry();
        t_clear();
        t_paging_off();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule